// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network-function layer of a 1-Wire slave. A bit-level physical layer beneath it reports three kinds of event: a bus reset has been detected, the master has written a bit, and the master has opened a read slot. The layer answers each read slot with a bit value, where 1 releases the line and 0 pulls it low. It holds a fixed 64-bit registration number, given as a parameter: the family code in the low byte, a 48-bit serial number above it and the CRC in the top byte.

After each bus reset the layer takes an 8-bit ROM command, least significant bit first. It serves four commands. Read returns the registration number. Match compares 64 bits from the master with that number. Search answers the three-slot elimination protocol. Skip selects the slave at once. A successful selection raises `selected_o` for the memory-function layer above. A failed match, a lost search or an unknown command leaves the slave silent until the next bus reset.

Top module: `onew_rom_layer`

## Requirements
- R1: After `rst_ni` deasserts, command bits are ignored until the first `bus_reset_i` pulse. `selected_o` is 0 and read slots return 1.
- R2: A `bus_reset_i` pulse aborts any command or data phase. It clears `selected_o` in the next cycle and makes the layer wait for a new command byte.
- R3: The 8 command bits are taken least significant bit first. Codes: 33h read, 55h match, F0h search, CCh skip.
- R4: After 33h, the next 64 read slots return registration bits 0 to 63 in order (bits 7:0 family code, 55:8 serial, 63:56 CRC). `selected_o` rises after the 64th slot.
- R5: After 55h, if all 64 written bits, taken LSB first, equal the registration number, `selected_o` rises after the 64th bit.
- R6: After 55h, any differing bit keeps `selected_o` low and makes all read slots return 1 until the next bus reset.
- R7: After F0h, for each registration bit starting at bit 0, the first read slot returns the bit, the second returns its complement, and then one written bit is taken as the master's choice.
- R8: In a search, a written bit that differs from the slave's bit ends its part in the search. Read slots return 1 and `selected_o` stays 0 until the next bus reset.
- R9: A search that survives all 64 bits raises `selected_o` after the last written bit.
- R10: CCh raises `selected_o` in the cycle after the 8th command bit, with no number exchange. `selected_o` then stays high until a bus reset.
- R11: Any other command byte leaves `selected_o` at 0 and read slots at 1 until the next bus reset.
- R12: Every read slot in which the slave is not transmitting returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | One-cycle pulse: physical layer detected a bus reset |
| wr_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| wr_bit_i | input | 1 | Value of the written bit |
| rd_req_i | input | 1 | One-cycle pulse: a read slot is being served |
| rd_bit_o | output | 1 | Bit for the current read slot (1 = release) |
| selected_o | output | 1 | Slave is selected for the memory layer |

## Verification
The bench sends Skip with its bits in LSB-first order. A layer that shifts in the wrong direction decodes this as Read and never selects. Match is tried once with the full number and once with a single bit flipped near the CRC. A design that drops the mismatch flag, or checks only part of the number, then selects wrongly. The search is run both to completion and with a lost choice at bit 5. Read slots after the loss must return 1, because a slave that kept transmitting would corrupt the other branches. Bus resets are injected in the middle of a Read and a Match to catch a layer that keeps a stale bit counter or stays selected.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ  = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SRCH  = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SKIP  = 8'hCC;

  typedef enum logic [2:0] {
    ST_WAIT_RST,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH,
    ST_DONE
  } rom_state_e;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_CMPL,
    PH_DIR
  } srch_ph_e;
endpackage

// File: rtl/onew_bit_cnt.sv
module onew_bit_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r2_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/onew_id_sel.sv
module onew_id_sel #(
  parameter int              ID_W  = 64,
  parameter int              IDX_W = 6,
  parameter logic [ID_W-1:0] ID    = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  logic [ID_W-1:0] id_vec;

  for (genvar g = 0; g < ID_W; g++) begin : g_id
    assign id_vec[g] = ID[g];
  end

  assign bit_o = id_vec[idx_i];
endmodule

// File: rtl/onew_rom_fsm.sv
module onew_rom_fsm
  import onew_rom_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int ID_W  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             wr_valid_i,
  input  logic             wr_bit_i,
  input  logic             rd_req_i,
  input  logic             id_bit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             rd_bit_o,
  output logic             selected_o
);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(ID_W - 1);

  rom_state_e       state_q;
  srch_ph_e         ph_q;
  logic [CMD_W-1:0] cmd_q, cmd_nx;
  logic             cmd_last, id_last, bit_eq;

  assign cmd_last = (cnt_i == CMD_LAST);
  assign id_last  = (cnt_i == ID_LAST);
  assign bit_eq   = (wr_bit_i == id_bit_i);
  assign cmd_nx   = {wr_bit_i, cmd_q[CMD_W-1:1]};  // LSB arrives first

  always_comb begin
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    if (bus_reset_i) cnt_clr_o = 1'b1;
    else begin
      unique case (state_q)
        ST_CMD:   if (wr_valid_i) begin
                    cnt_clr_o = cmd_last;
                    cnt_inc_o = !cmd_last;
                  end
        ST_READ:  cnt_inc_o = rd_req_i;
        ST_MATCH: cnt_inc_o = wr_valid_i;
        ST_SRCH:  cnt_inc_o = wr_valid_i && (ph_q == PH_DIR) && bit_eq;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_bit_o = 1'b1;
    if (state_q == ST_READ) rd_bit_o = id_bit_i;
    else if (state_q == ST_SRCH) begin
      if (ph_q == PH_TRUE)      rd_bit_o = id_bit_i;
      else if (ph_q == PH_CMPL) rd_bit_o = !id_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT_RST;
      ph_q       <= PH_TRUE;
      cmd_q      <= '0;
      selected_o <= 1'b0;
    end else if (bus_reset_i) begin
      state_q    <= ST_CMD;
      ph_q       <= PH_TRUE;
      selected_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (wr_valid_i) begin
          cmd_q <= cmd_nx;
          if (cmd_last) begin
            ph_q <= PH_TRUE;
            case (cmd_nx)
              CMD_READ:  state_q <= ST_READ;
              CMD_MATCH: state_q <= ST_MATCH;
              CMD_SRCH:  state_q <= ST_SRCH;
              CMD_SKIP:  begin state_q <= ST_DONE; selected_o <= 1'b1; end
              default:   state_q <= ST_WAIT_RST;
            endcase
          end
        end
        ST_READ: if (rd_req_i && id_last) begin
          state_q    <= ST_DONE;
          selected_o <= 1'b1;
        end
        ST_MATCH: if (wr_valid_i) begin
          if (!bit_eq)      state_q <= ST_WAIT_RST;
          else if (id_last) begin state_q <= ST_DONE; selected_o <= 1'b1; end
        end
        ST_SRCH: begin
          unique case (ph_q)
            PH_TRUE: if (rd_req_i) ph_q <= PH_CMPL;
            PH_CMPL: if (rd_req_i) ph_q <= PH_DIR;
            default: if (wr_valid_i) begin
              if (!bit_eq)      state_q <= ST_WAIT_RST;
              else if (id_last) begin state_q <= ST_DONE; selected_o <= 1'b1; end
              else              ph_q <= PH_TRUE;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  a_r2_reset_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!selected_o && state_q == ST_CMD));
  a_r8_stay_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_RST && !bus_reset_i) |=>
      (state_q == ST_WAIT_RST && rd_bit_o && !selected_o));
  a_r7_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SRCH && ph_q == PH_TRUE && rd_req_i && !bus_reset_i) |=>
      (rd_bit_o != $past(rd_bit_o)));
  a_r10_sel_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected_o && !bus_reset_i) |=> selected_o);
  a_r12_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD || state_q == ST_DONE) |-> rd_bit_o);
endmodule

// File: rtl/onew_rom_layer.sv
module onew_rom_layer #(
  parameter int              ID_W = 64,
  parameter logic [ID_W-1:0] ID   = 64'h8C_5E3A9C71F0B4_17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic wr_valid_i,
  input  logic wr_bit_i,
  input  logic rd_req_i,
  output logic rd_bit_o,
  output logic selected_o
);
  localparam int CNT_W = $clog2(ID_W);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc, id_bit;

  onew_bit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  onew_id_sel #(.ID_W(ID_W), .IDX_W(CNT_W), .ID(ID)) u_sel (
    .idx_i (cnt),
    .bit_o (id_bit)
  );

  onew_rom_fsm #(.CNT_W(CNT_W), .ID_W(ID_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .wr_valid_i  (wr_valid_i),
    .wr_bit_i    (wr_bit_i),
    .rd_req_i    (rd_req_i),
    .id_bit_i    (id_bit),
    .cnt_i       (cnt),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .rd_bit_o    (rd_bit_o),
    .selected_o  (selected_o)
  );
endmodule

// File: tb/sim_onew_rom_layer.sv
module sim_onew_rom_layer;
  localparam time PER = 10ns;
  localparam logic [63:0] ID = 64'h8C_5E3A9C71F0B4_17;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_reset = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_req = 1'b0;
  logic rd_bit, selected;

  int total = 0, bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(PER/2) clk = ~clk;

  onew_rom_layer #(.ID_W(64), .ID(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset),
    .wr_valid_i(wr_valid), .wr_bit_i(wr_bit), .rd_req_i(rd_req),
    .rd_bit_o(rd_bit), .selected_o(selected)
  );

  // monitor: compares each served read slot against the scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (rd_req) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read slot act=%b exp=none", rd_bit);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_bit !== e) begin
          bad++;
          $display("FAIL %s rd_bit act=%b exp=%b", t, rd_bit, e);
        end
      end
    end
  end

  task automatic bus_rst();
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
  endtask

  task automatic wr1(input bit b);
    @(negedge clk) begin wr_valid = 1'b1; wr_bit = b; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr1(v[i]);
  endtask

  task automatic rd_exp(input bit e, input string t);
    @(negedge clk) begin exp_q.push_back(e); tag_q.push_back(t); rd_req = 1'b1; end
    @(negedge clk) rd_req = 1'b0;
  endtask

  task automatic chk_sel(input bit e, input string t);
    @(negedge clk);
    #2;
    total++;
    if (selected !== e) begin
      bad++;
      $display("FAIL %s selected act=%b exp=%b", t, selected, e);
    end
  endtask

  initial begin
    #(PER * 100000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: no command before first bus reset
    chk_sel(1'b0, "R1 reset state");
    rd_exp(1'b1, "R1 idle read");
    wr_byte(8'hCC);
    chk_sel(1'b0, "R1 skip before bus reset");

    // R10/R3: skip, LSB first
    bus_rst();
    wr_byte(8'hCC);
    chk_sel(1'b1, "R10 R3 skip selects");
    rd_exp(1'b1, "R12 selected idle read");
    bus_rst();
    chk_sel(1'b0, "R2 bus reset clears");

    // R4: read rom
    bus_rst();
    wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk_sel(1'b0, "R4 not yet selected");
      rd_exp(ID[i], "R4 id bit");
    end
    chk_sel(1'b1, "R4 selected after read");

    // R5: match success
    bus_rst();
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr1(ID[i]);
    chk_sel(1'b1, "R5 match selects");

    // R6: match fail at bit 60
    bus_rst();
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr1(i == 60 ? !ID[i] : ID[i]);
    chk_sel(1'b0, "R6 mismatch unselected");
    rd_exp(1'b1, "R6 quiet read");
    rd_exp(1'b1, "R6 quiet read");

    // R7/R9: full search
    bus_rst();
    wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd_exp(ID[i], "R7 true bit");
      rd_exp(!ID[i], "R7 complement bit");
      wr1(ID[i]);
    end
    chk_sel(1'b1, "R9 search selects");

    // R8: lose at bit 5
    bus_rst();
    wr_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rd_exp(ID[i], "R7 true bit");
      rd_exp(!ID[i], "R7 complement bit");
      wr1(i == 5 ? !ID[i] : ID[i]);
    end
    for (int i = 0; i < 4; i++) rd_exp(1'b1, "R8 dropped read");
    for (int i = 0; i < 6; i++) wr1(ID[6 + i]);
    chk_sel(1'b0, "R8 dropped unselected");

    // R11: unknown command
    bus_rst();
    wr_byte(8'h3C);
    rd_exp(1'b1, "R11 unknown read");
    wr_byte(8'hCC);
    chk_sel(1'b0, "R11 unknown unselected");

    // R2: abort mid read, then mid match
    bus_rst();
    wr_byte(8'h33);
    for (int i = 0; i < 10; i++) rd_exp(ID[i], "R4 id bit");
    bus_rst();
    wr_byte(8'hCC);
    chk_sel(1'b1, "R2 abort read then skip");
    bus_rst();
    wr_byte(8'h55);
    for (int i = 0; i < 20; i++) wr1(ID[i]);
    bus_rst();
    wr_byte(8'h33);
    for (int i = 0; i < 3; i++) rd_exp(ID[i], "R2 abort match then read");

    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard act=%0d exp=0 pending", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule